// File: doc/BRIEF.md
# Quorum Pattern Matching Bank

This block keeps a bank of stored patterns, each a row of several fixed-width word slots. Incoming search vectors carry one search word per word position. Word position k is checked only against slot k of every row, and all rows are checked in the same cycle. A slot that equals its search word in every bit sets a match flag. The flag stays set across any number of search cycles until an explicit clear, so the flags of one event build up over several search vectors.

A scan request freezes the flags into a per-row match register and latches a threshold. A row qualifies when the number of set bits in its match register is greater than that threshold. The qualifying rows are then handed out one per handshake, lowest row first. Each carries its row address and the mask of word positions that matched. A one-cycle done pulse closes the scan.

Patterns are loaded one word per cycle through a row/word address port. A two-bit mode input enables the write path, the search path, both or neither.

Top module: `patmatch_bank`

## Requirements
- R1: After reset, outValid and scanDone are low, every stored word is zero and every match flag is clear, so a scan with threshold 0 returns no rows.
- R2: When modeSel bit 0 is 1, wrData is stored into word slot wrWord of row wrRow at the clock edge, and no other slot changes; when modeSel bit 0 is 0 nothing is stored.
- R3: When modeSel bit 1 is 1, search word k (srchData bits [18k+17:18k]) sets the flag of slot k in every row whose stored word equals it in all 18 bits; a single differing bit gives no match; when modeSel bit 1 is 0 no flag changes.
- R4: Match flags are sticky: flags set by several search cycles accumulate until cleared, and a scan does not clear them.
- R5: clear zeros all match flags at the clock edge and wins over a hit from a search in the same cycle.
- R6: At scanGo the flags are copied into the match registers and threshold is latched; a row qualifies when its count of set match bits is strictly greater than that threshold (0..8).
- R7: Qualifying rows are presented in ascending row order, one per cycle in which outValid and outReady are both high; outRow and outMask hold steady while outReady is low.
- R8: scanDone pulses for exactly one cycle after the last row is accepted, or directly when no row qualifies; outValid or scanDone is high after the second rising edge counted from the edge that samples scanGo; scanGo is ignored while a scan is in progress.
- R9: When a write and a search fall in the same cycle (modeSel = 3), the search compares against the contents held before that write.
- R10: Searches during a scan do not change the masks or the set of rows that scan reports; their flags appear in the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Bit 0 enables the write path, bit 1 enables the search path |
| wrRow | input | 6 | Row address for a write |
| wrWord | input | 3 | Word slot index for a write |
| wrData | input | 18 | Write data |
| srchData | input | 144 | Eight search words, word k at bits [18k+17:18k] |
| clear | input | 1 | Zero all match flags |
| threshold | input | 4 | Quorum threshold, latched at scanGo |
| scanGo | input | 1 | Start a scan and readout |
| outReady | input | 1 | Consumer accepts the current row |
| outValid | output | 1 | outRow and outMask hold a qualifying row |
| outRow | output | 6 | Address of the reported row |
| outMask | output | 8 | Matched word positions of the reported row |
| scanDone | output | 1 | One-cycle end-of-scan pulse |

## Verification
A write and a search can act in the same cycle, and so can a search and a scan capture or readout. The bench drives mode 3 with the search word equal to the data being written. A correct bank reports no hit for that word, and a later search of the same word hits. The bench then runs a search that hits a new row while a report is held with outReady low. It judges the held mask, the absence of that row in the current scan and its presence in the next one.

// File: rtl/patmatch_pkg.sv
package patmatch_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // copy flags into match registers, latch threshold
    logic loadPend;  // load qualifying rows into the pending set
    logic pop;       // drop the lowest pending row
  } ctlStrobe_t;
endpackage

// File: rtl/patmatch_dp.sv
module patmatch_dp
  import patmatch_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int WORDS  = 8,
  parameter int ROWS   = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int IDX_W = $clog2(WORDS),
  localparam int THR_W = $clog2(WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEnable,
  input  logic                    srchEnable,
  input  logic                    clear,
  input  logic [ROW_W-1:0]        wrRow,
  input  logic [IDX_W-1:0]        wrWord,
  input  logic [WORD_W-1:0]       wrData,
  input  logic [WORDS*WORD_W-1:0] srchData,
  input  logic [THR_W-1:0]        threshold,
  input  ctlStrobe_t              ctl,
  output logic                    anyPending,
  output logic [ROW_W-1:0]        outRow,
  output logic [WORDS-1:0]        outMask
);

  logic [WORD_W-1:0] cells    [ROWS][WORDS];
  logic [WORDS-1:0]  hitRow   [ROWS];
  logic [WORDS-1:0]  flags    [ROWS];
  logic [WORDS-1:0]  matchReg [ROWS];
  logic [ROWS-1:0]   rowSel;
  logic [ROWS-1:0]   qual;
  logic [ROWS-1:0]   pending;
  logic [ROWS-1:0]   lowestHot;
  logic [THR_W-1:0]  thrReg;
  logic [ROW_W-1:0]  lowIdx;
  logic [ROWS*WORDS-1:0] flagsFlat;

  function automatic logic [THR_W-1:0] popCnt(input logic [WORDS-1:0] v);
    logic [THR_W-1:0] s;
    s = '0;
    for (int i = 0; i < WORDS; i++) s = s + THR_W'(v[i]);
    return s;
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rowSel[r] = wrEnable && (wrRow == ROW_W'(r));

    for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)
          cells[r][k] <= '0;
        else if (rowSel[r] && (wrWord == IDX_W'(k)))
          cells[r][k] <= wrData;
      end
      assign hitRow[r][k] = (cells[r][k] == srchData[k*WORD_W +: WORD_W]);
    end

    // sticky per-word match latches
    always_ff @(posedge clk) begin
      if (!rstN)
        flags[r] <= '0;
      else if (clear)
        flags[r] <= '0;
      else if (srchEnable)
        flags[r] <= flags[r] | hitRow[r];
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        matchReg[r] <= '0;
      else if (ctl.capture)
        matchReg[r] <= flags[r];
    end

    assign qual[r] = popCnt(matchReg[r]) > thrReg;
    assign flagsFlat[r*WORDS +: WORDS] = flags[r];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      thrReg <= '0;
    else if (ctl.capture)
      thrReg <= threshold;
  end

  assign lowestHot = pending & (~pending + ROWS'(1));

  always_ff @(posedge clk) begin
    if (!rstN)
      pending <= '0;
    else if (ctl.loadPend)
      pending <= qual;
    else if (ctl.pop)
      pending <= pending & ~lowestHot;
  end

  always_comb begin
    lowIdx = '0;
    for (int i = ROWS - 1; i >= 0; i--)
      if (pending[i]) lowIdx = ROW_W'(i);
  end

  assign anyPending = |pending;
  assign outRow     = lowIdx;
  assign outMask    = matchReg[lowIdx];

  // R2
  wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> ((flagsFlat & $past(flagsFlat)) == $past(flagsFlat)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (flagsFlat == '0));

  // R3
  srch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srchEnable && !clear) |=> $stable(flagsFlat));

  // R7
  ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |=> (!anyPending || (outRow > $past(outRow))));

endmodule

// File: rtl/patmatch_ctl.sv
module patmatch_ctl
  import patmatch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scanGo,
  input  logic       outReady,
  input  logic       anyPending,
  output ctlStrobe_t ctl,
  output logic       outValid,
  output logic       scanDone
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SEND} scanState_t;
  scanState_t state, nextState;

  always_comb begin
    ctl       = '0;
    outValid  = 1'b0;
    scanDone  = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (scanGo) begin
        ctl.capture = 1'b1;
        nextState   = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.loadPend = 1'b1;
        nextState    = ST_SEND;
      end
      ST_SEND: begin
        if (anyPending) begin
          outValid = 1'b1;
          ctl.pop  = outReady;
        end else begin
          scanDone  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !outValid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

endmodule

// File: rtl/patmatch_bank.sv
module patmatch_bank
  import patmatch_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int WORDS  = 8,
  parameter int ROWS   = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int IDX_W = $clog2(WORDS),
  localparam int THR_W = $clog2(WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              modeSel,
  input  logic [ROW_W-1:0]        wrRow,
  input  logic [IDX_W-1:0]        wrWord,
  input  logic [WORD_W-1:0]       wrData,
  input  logic [WORDS*WORD_W-1:0] srchData,
  input  logic                    clear,
  input  logic [THR_W-1:0]        threshold,
  input  logic                    scanGo,
  input  logic                    outReady,
  output logic                    outValid,
  output logic [ROW_W-1:0]        outRow,
  output logic [WORDS-1:0]        outMask,
  output logic                    scanDone
);

  ctlStrobe_t ctl;
  logic       anyPending;

  patmatch_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .scanGo     (scanGo),
    .outReady   (outReady),
    .anyPending (anyPending),
    .ctl        (ctl),
    .outValid   (outValid),
    .scanDone   (scanDone)
  );

  patmatch_dp #(
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .ROWS   (ROWS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEnable   (modeSel[0]),
    .srchEnable (modeSel[1]),
    .clear      (clear),
    .wrRow      (wrRow),
    .wrWord     (wrWord),
    .wrData     (wrData),
    .srchData   (srchData),
    .threshold  (threshold),
    .ctl        (ctl),
    .anyPending (anyPending),
    .outRow     (outRow),
    .outMask    (outMask)
  );

endmodule

// File: tb/sim_patmatch_bank.sv
module sim_patmatch_bank;

  localparam logic [17:0] NOMATCH = 18'h3FFFF;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   modeSel = '0;
  logic [5:0]   wrRow = '0;
  logic [2:0]   wrWord = '0;
  logic [17:0]  wrData = '0;
  logic [143:0] srchData = '0;
  logic         clear = 1'b0;
  logic [3:0]   threshold = '0;
  logic         scanGo = 1'b0;
  logic         outReady = 1'b0;
  logic         outValid;
  logic [5:0]   outRow;
  logic [7:0]   outMask;
  logic         scanDone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gotN;
  int gotRow [64];
  int gotMask [64];

  always #2 clk = ~clk;

  patmatch_bank u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .wrRow(wrRow), .wrWord(wrWord),
    .wrData(wrData), .srchData(srchData), .clear(clear), .threshold(threshold),
    .scanGo(scanGo), .outReady(outReady), .outValid(outValid), .outRow(outRow),
    .outMask(outMask), .scanDone(scanDone)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // stimulus table: {row[6], mask[8], threshold[4]}
  localparam logic [17:0] VEC [8] = '{
    {6'd10, 8'hFF, 4'd7}, {6'd10, 8'hFF, 4'd8}, {6'd0,  8'h01, 4'd0},
    {6'd63, 8'h80, 4'd1}, {6'd33, 8'h0F, 4'd3}, {6'd33, 8'h0F, 4'd4},
    {6'd17, 8'hAA, 4'd3}, {6'd50, 8'h55, 4'd4}
  };

  function automatic logic [17:0] pat(int r, int k);
    return {6'(r), 3'(k), 9'h0A5 ^ 9'(r)};
  endfunction

  function automatic logic [143:0] keyFor(int r, logic [7:0] m);
    logic [143:0] v;
    for (int k = 0; k < 8; k++) v[k*18 +: 18] = m[k] ? pat(r, k) : NOMATCH;
    return v;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chkEq(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(int r, int k, logic [17:0] d);
    modeSel = 2'b01; wrRow = 6'(r); wrWord = 3'(k); wrData = d;
    tick;
    modeSel = 2'b00;
  endtask

  task automatic doSearch(logic [143:0] key);
    modeSel = 2'b10; srchData = key;
    tick;
    modeSel = 2'b00; srchData = '1;
  endtask

  task automatic doClear;
    clear = 1'b1;
    tick;
    clear = 1'b0;
  endtask

  task automatic doScan(logic [3:0] thr);
    gotN = 0;
    outReady = 1'b1;
    threshold = thr;
    scanGo = 1'b1;
    tick;
    scanGo = 1'b0;
    tick;
    chkEq("R8 latency", int'(outValid | scanDone), 1);
    for (int i = 0; i < 80; i++) begin
      if (scanDone) break;
      if (outValid) begin
        gotRow[gotN] = int'(outRow);
        gotMask[gotN] = int'(outMask);
        gotN++;
      end
      tick;
    end
    chkEq("R8 done seen", int'(scanDone), 1);
    tick;
    chkEq("R8 done one cycle", int'(scanDone), 0);
  endtask

  initial begin
    srchData = '1;
    tick; tick; tick;
    rstN = 1'b1;
    tick;
    // R1 reset state
    chkEq("R1 outValid", int'(outValid), 0);
    chkEq("R1 scanDone", int'(scanDone), 0);
    doScan(4'd0);
    chkEq("R1 no rows after reset", gotN, 0);

    for (int r = 0; r < 64; r++)
      for (int k = 0; k < 8; k++) doWrite(r, k, pat(r, k));

    // table walk: R2 R3 R6 R7
    for (int i = 0; i < 8; i++) begin
      int r;
      logic [7:0] m;
      logic [3:0] t;
      int expN;
      r = int'(VEC[i][17:12]); m = VEC[i][11:4]; t = VEC[i][3:0];
      expN = ($countones(m) > int'(t)) ? 1 : 0;
      doClear;
      doSearch(keyFor(r, m));
      doScan(t);
      chkEq("R6 qualify count", gotN, expN);
      if (expN == 1 && gotN == 1) begin
        chkEq("R7 row", gotRow[0], r);
        chkEq("R3 mask", gotMask[0], int'(m));
      end
    end

    // R4 sticky accumulation, R7 ascending order and hold
    begin
      logic [143:0] kA, kB;
      doClear;
      for (int k = 0; k < 8; k++) kA[k*18 +: 18] = (k < 3) ? pat(40, k) : pat(5, k);
      for (int k = 0; k < 8; k++)
        kB[k*18 +: 18] = (k < 3) ? pat(20, k) : ((k < 6) ? pat(40, k) : NOMATCH);
      doSearch(kA);
      doSearch(kB);
      outReady = 1'b0; threshold = 4'd2; scanGo = 1'b1;
      tick;
      scanGo = 1'b0;
      tick; tick; tick;
      chkEq("R7 hold valid", int'(outValid), 1);
      chkEq("R7 hold row", int'(outRow), 5);
      chkEq("R4 row5 mask", int'(outMask), 'hF8);
      outReady = 1'b1;
      tick;
      chkEq("R7 second row", int'(outRow), 20);
      chkEq("R4 row20 mask", int'(outMask), 'h07);
      tick;
      chkEq("R7 third row", int'(outRow), 40);
      chkEq("R4 row40 accumulated", int'(outMask), 'h3F);
      tick;
      chkEq("R8 done after last", int'(scanDone), 1);
      tick;
    end

    // R3 gating and single-bit miss
    doClear;
    modeSel = 2'b00; srchData = keyFor(12, 8'hFF);
    tick;
    srchData = '1;
    doScan(4'd0);
    chkEq("R3 search disabled", gotN, 0);
    begin
      logic [143:0] kx;
      kx = keyFor(12, 8'h01);
      kx[0] = ~kx[0];
      doSearch(kx);
    end
    doScan(4'd0);
    chkEq("R3 one bit differs", gotN, 0);
    doSearch(keyFor(12, 8'hFF));
    doScan(4'd7);
    chkEq("R3 full row count", gotN, 1);
    chkEq("R3 full row id", gotRow[0], 12);

    // R2 write blocked when bit 0 low
    doClear;
    modeSel = 2'b10; wrRow = 6'd3; wrWord = 3'd0; wrData = 18'h12345; srchData = '1;
    tick;
    modeSel = 2'b00;
    doClear;
    doSearch({{7{NOMATCH}}, 18'h12345});
    doScan(4'd0);
    chkEq("R2 no write in compare mode", gotN, 0);
    doSearch({{7{NOMATCH}}, pat(3, 0)});
    doScan(4'd0);
    chkEq("R2 old word kept count", gotN, 1);
    chkEq("R2 old word kept row", gotRow[0], 3);

    // R5 clear wins over same-cycle hit
    doClear;
    modeSel = 2'b10; srchData = keyFor(4, 8'hFF); clear = 1'b1;
    tick;
    modeSel = 2'b00; clear = 1'b0; srchData = '1;
    doScan(4'd0);
    chkEq("R5 clear priority", gotN, 0);

    // R9 write and search in same cycle
    doClear;
    modeSel = 2'b11; wrRow = 6'd7; wrWord = 3'd2; wrData = 18'h2AAAA;
    srchData = {{5{NOMATCH}}, 18'h2AAAA, NOMATCH, NOMATCH};
    tick;
    modeSel = 2'b00; srchData = '1;
    doScan(4'd0);
    chkEq("R9 search sees old contents", gotN, 0);
    doSearch({{5{NOMATCH}}, 18'h2AAAA, NOMATCH, NOMATCH});

    // R10 search during readout, R8 scanGo ignored while busy
    outReady = 1'b0; threshold = 4'd0; scanGo = 1'b1;
    tick;
    scanGo = 1'b0;
    tick;
    chkEq("R9 new word hit row", int'(outRow), 7);
    chkEq("R9 new word mask", int'(outMask), 'h04);
    modeSel = 2'b10; srchData = keyFor(9, 8'hFF); scanGo = 1'b1;
    tick;
    modeSel = 2'b00; srchData = '1; scanGo = 1'b0;
    chkEq("R10 row held", int'(outRow), 7);
    chkEq("R10 mask held", int'(outMask), 'h04);
    outReady = 1'b1;
    tick;
    chkEq("R10 no new row in scan", int'(outValid), 0);
    chkEq("R10 done", int'(scanDone), 1);
    tick;
    tick;
    chkEq("R8 busy scanGo ignored valid", int'(outValid), 0);
    chkEq("R8 busy scanGo ignored done", int'(scanDone), 0);
    doScan(4'd0);
    chkEq("R10 next scan count", gotN, 2);
    chkEq("R10 next scan row9", gotRow[1], 9);
    chkEq("R10 next scan mask9", gotMask[1], 'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule